// File: doc/BRIEF.md
# Key-Protected Program Memory Write Sequencer

This block sequences program and erase operations on an on-chip program memory held as a behavioural word array. Software reaches it through a small register bus. The bus has a control register, a key register that accepts writes and always reads as zero, an address register, a pair of data registers that fill a one-row holding buffer, and a pair of read-back registers that return the array word at the current address. An operation starts only if the control write is the access that immediately follows a two-write unlock sequence on the key register. When an operation starts, `stall` rises and holds the processor for a fixed number of cycles. The array is changed in the last of those cycles.

There are three operations. A single-word program copies one buffered word to one array word. A row program copies all 64 buffered words into a 64-word aligned row. A page erase sets a 512-word aligned page (eight rows) to all ones. Each word is 24 bits wide. A word is loaded as a low 16-bit half followed by an upper 8-bit half. The buffer slot is chosen by a pointer that wraps inside one 64-word group.

Top module: `flash_prog_ctl`

## Requirements
- R1: After reset, the control register reads 0, `stall` is low, and every array word reads as all ones: 0xFFFF from the low read register (sel 5) and 0x00FF from the high read register (sel 6).
- R2: The key register (sel 1) always reads 0x0000.
- R3: The unlock sequence is a write of 0x0055 to sel 1, then a write of 0x00AA to sel 1 as the next bus access. If the next access after that is a control write (sel 0) with bit 15 set, a valid operation code in bits 1:0 and a correctly aligned address, the operation starts. Bit 15 of the control register reads 0 once the operation has finished.
- R4: A start attempt is ignored and the error flag (control bit 13) is set if the unlock was broken by a wrong key value, or if any other access came between the two key writes or between the second key write and the start.
- R5: An unlock is used up by one start attempt, whether the attempt succeeds or fails. A second attempt without a new key sequence fails.
- R6: A row program needs address bits 5:0 to be zero. A page erase needs address bits 8:0 to be zero. Operation code 00 is never valid. A failed start sets the error flag, leaves the array unchanged and does not raise `stall`.
- R7: Once an operation starts, `stall` stays high for WORD_CYCLES, ROW_CYCLES or ERASE_CYCLES clock cycles. The operation codes are 01 for word program, 10 for row program and 11 for page erase.
- R8: A write to the address register (sel 2) sets the buffer pointer to address bits 5:0. A write to sel 3 latches the low 16 bits of a word. A write to sel 4 stores {wdata[7:0], latched low half} at the pointer and advances the pointer modulo 64. `stall` is high for the one cycle after each sel 4 write.
- R9: A row program copies buffer slots 0 to 63 into the 64 words of the row that holds the address.
- R10: A page erase sets all 512 words of the addressed page to all ones and leaves every other page as it was.
- R11: A word program writes buffer slot (address mod 64) to the addressed word only.
- R12: A control write with bit 15 clear and bit 13 clear clears the error flag. A successful start also clears it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 3 | Register select: 0 control, 1 key, 2 address, 3 data low, 4 data high, 5 read low, 6 read high |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for the selected register while bus_rd is high |
| stall | output | 1 | Holds the processor during an operation and for one cycle after each buffer write |

## Verification
The assertions assume that the processor issues no bus access while `stall` is high. Under that assumption, a start write that is accepted can only come straight after the second key write. They also assume that read and write strobes are never high together. The stimulus keeps to both rules: every access lasts one cycle, and the next access is held back until `stall` has fallen. Accesses that break the unlock are ordinary reads and writes, placed between the key writes or between the last key write and the start.

// File: rtl/flash_prog_ctl.sv
module flash_prog_ctl #(
  parameter int WORD_W       = 24,
  parameter int ROW_WORDS    = 64,
  parameter int PAGE_ROWS    = 8,
  parameter int NUM_PAGES    = 2,
  parameter int ROW_CYCLES   = 11064,
  parameter int ERASE_CYCLES = 11064,
  parameter int WORD_CYCLES  = 11064
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [2:0]  bus_sel,
  input  logic        bus_wr,
  input  logic        bus_rd,
  input  logic [15:0] bus_wdata,
  output logic [15:0] bus_rdata,
  output logic        stall
);
  localparam int PAGE_WORDS = ROW_WORDS * PAGE_ROWS;
  localparam int NWORDS     = PAGE_WORDS * NUM_PAGES;
  localparam int AW         = $clog2(NWORDS);
  localparam int RW         = $clog2(ROW_WORDS);
  localparam int HI_W       = WORD_W - 16;
  localparam int MAXC       = (ROW_CYCLES > ERASE_CYCLES) ?
                              ((ROW_CYCLES > WORD_CYCLES) ? ROW_CYCLES : WORD_CYCLES) :
                              ((ERASE_CYCLES > WORD_CYCLES) ? ERASE_CYCLES : WORD_CYCLES);
  localparam int CW         = $clog2(MAXC + 1);

  localparam logic [2:0] SEL_CTRL = 3'd0, SEL_KEY = 3'd1, SEL_ADDR = 3'd2,
                         SEL_DLO = 3'd3, SEL_DHI = 3'd4, SEL_RLO = 3'd5, SEL_RHI = 3'd6;
  localparam logic [1:0] OP_WORD = 2'b01, OP_ROW = 2'b10, OP_ERASE = 2'b11;
  localparam logic [1:0] KEY_IDLE = 2'd0, KEY_HALF = 2'd1, KEY_OPEN = 2'd2;

  logic [WORD_W-1:0] mem    [NWORDS];
  logic [WORD_W-1:0] rowbuf [ROW_WORDS];
  logic [AW-1:0]     addr;
  logic [RW-1:0]     ptr;
  logic [15:0]       lo_latch;
  logic [1:0]        op;
  logic [1:0]        key_st;
  logic              err, busy, bwait;
  logic [CW-1:0]     cnt;

  wire        acc       = (bus_wr | bus_rd) & ~stall;
  wire        wr        = bus_wr & ~stall;
  wire [1:0]  op_new    = bus_wdata[1:0];
  wire        ctrl_wr   = wr && bus_sel == SEL_CTRL;
  wire        start_try = ctrl_wr && bus_wdata[15];
  wire        row_al    = (addr & AW'(ROW_WORDS - 1)) == '0;
  wire        page_al   = (addr & AW'(PAGE_WORDS - 1)) == '0;
  wire        op_fit    = (op_new == OP_WORD) ||
                          (op_new == OP_ROW && row_al) ||
                          (op_new == OP_ERASE && page_al);
  wire        start_ok  = start_try && key_st == KEY_OPEN && op_fit;
  wire        last_tick = busy && cnt == CW'(1);
  wire [AW-1:0] row_base  = addr & ~AW'(ROW_WORDS - 1);
  wire [AW-1:0] page_base = addr & ~AW'(PAGE_WORDS - 1);

  assign stall = busy | bwait;

  function automatic logic [CW-1:0] op_len(input logic [1:0] o);
    case (o)
      OP_WORD:  op_len = CW'(WORD_CYCLES);
      OP_ROW:   op_len = CW'(ROW_CYCLES);
      default:  op_len = CW'(ERASE_CYCLES);
    endcase
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      key_st <= KEY_IDLE;
    end else if (acc) begin
      case (key_st)
        KEY_IDLE: key_st <= (wr && bus_sel == SEL_KEY && bus_wdata == 16'h0055) ? KEY_HALF : KEY_IDLE;
        KEY_HALF: key_st <= (wr && bus_sel == SEL_KEY && bus_wdata == 16'h00AA) ? KEY_OPEN : KEY_IDLE;
        default:  key_st <= KEY_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      op    <= '0;
      err   <= 1'b0;
      busy  <= 1'b0;
      cnt   <= '0;
      bwait <= 1'b0;
    end else begin
      bwait <= wr && bus_sel == SEL_DHI;
      if (ctrl_wr) begin
        op  <= op_new;
        err <= start_try ? !start_ok : (err & bus_wdata[13]);
      end
      if (start_ok) begin
        busy <= 1'b1;
        cnt  <= op_len(op_new);
      end else if (last_tick) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else if (busy) begin
        cnt <= cnt - CW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr     <= '0;
      ptr      <= '0;
      lo_latch <= '0;
      for (int i = 0; i < ROW_WORDS; i++) rowbuf[i] <= '1;
    end else if (wr) begin
      case (bus_sel)
        SEL_ADDR: begin
          addr <= bus_wdata[AW-1:0];
          ptr  <= bus_wdata[RW-1:0];
        end
        SEL_DLO: lo_latch <= bus_wdata;
        SEL_DHI: begin
          rowbuf[ptr] <= {bus_wdata[HI_W-1:0], lo_latch};
          ptr         <= ptr + RW'(1);
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NWORDS; i++) mem[i] <= '1;
    end else if (last_tick) begin
      case (op)
        OP_WORD:  mem[addr] <= rowbuf[addr[RW-1:0]];
        OP_ROW:   for (int j = 0; j < ROW_WORDS; j++) mem[row_base | AW'(j)] <= rowbuf[j];
        OP_ERASE: for (int j = 0; j < PAGE_WORDS; j++) mem[page_base | AW'(j)] <= '1;
        default: ;
      endcase
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_sel)
        SEL_CTRL: bus_rdata = {busy, 1'b0, err, 11'b0, op};
        SEL_ADDR: bus_rdata = 16'(addr);
        SEL_RLO:  bus_rdata = mem[addr][15:0];
        SEL_RHI:  bus_rdata = 16'(mem[addr][WORD_W-1:16]);
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

module flash_prog_ctl_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [2:0]  bus_sel,
  input logic        bus_wr,
  input logic        bus_rd,
  input logic [15:0] bus_wdata,
  input logic [15:0] bus_rdata,
  input logic        stall,
  input logic        busy,
  input logic        err,
  input logic        unlocked,
  input logic        row_aligned,
  input logic        last_tick
);
  assert_key_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_sel == 3'd1) |-> bus_rdata == 16'h0000);

  assert_start_bit_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && !stall && bus_sel == 3'd0) |-> !bus_rdata[15]);

  assert_locked_start_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !stall && bus_sel == 3'd0 && bus_wdata[15] && !unlocked) |=> (!busy && err));

  assert_misaligned_row_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !stall && bus_sel == 3'd0 && bus_wdata[15] && bus_wdata[1:0] == 2'b10 && !row_aligned)
      |=> (!busy && err));

  assert_busy_holds_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !last_tick) |=> busy);

  assert_busy_ends_R7: assert property (@(posedge clk) disable iff (!rst_n)
    last_tick |=> !busy);

  assert_buffer_wait_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !stall && bus_sel == 3'd4) |=> stall);
endmodule

bind flash_prog_ctl flash_prog_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .stall(stall), .busy(busy), .err(err),
  .unlocked(key_st == 2'd2), .row_aligned(row_al), .last_tick(last_tick)
);

// File: tb/flash_prog_ctl_test.sv
module flash_prog_ctl_test;
  localparam int ROWC = 40, ERC = 50, WDC = 12;
  localparam int NW = 1024;

  logic clk = 0, rst_n = 0;
  logic [2:0] bus_sel = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [15:0] bus_wdata = 0, bus_rdata;
  logic stall;

  always #4 clk = ~clk;

  flash_prog_ctl #(.ROW_CYCLES(ROWC), .ERASE_CYCLES(ERC), .WORD_CYCLES(WDC)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .stall(stall));

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_req = "R1";

  logic [23:0] mmem [NW];
  logic [23:0] mbuf [64];
  int maddr, mptr, mop, mcnt, mkey;
  logic [15:0] mlo;
  bit merr, mbw;

  function automatic logic [15:0] exp_rdata(input logic [2:0] s);
    case (s)
      3'd0: return {(mcnt > 0) ? 1'b1 : 1'b0, 1'b0, merr, 11'b0, 2'(mop)};
      3'd2: return 16'(maddr);
      3'd5: return mmem[maddr][15:0];
      3'd6: return {8'h00, mmem[maddr][23:16]};
      default: return 16'h0000;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NW; i++) mmem[i] = 24'hFFFFFF;
      for (int i = 0; i < 64; i++) mbuf[i] = 24'hFFFFFF;
      maddr = 0; mptr = 0; mop = 0; mcnt = 0; mkey = 0; mlo = 0; merr = 0; mbw = 0;
    end else begin
      bit st, a, w, ok;
      int oldkey;
      st = (mcnt > 0) || mbw;
      a = (bus_wr || bus_rd) && !st;
      w = bus_wr && !st;
      oldkey = mkey;
      mbw = 0;
      if (mcnt > 0) begin
        mcnt--;
        if (mcnt == 0) begin
          if (mop == 1) mmem[maddr] = mbuf[maddr % 64];
          else if (mop == 2) for (int j = 0; j < 64; j++) mmem[(maddr / 64) * 64 + j] = mbuf[j];
          else if (mop == 3) for (int j = 0; j < 512; j++) mmem[(maddr / 512) * 512 + j] = 24'hFFFFFF;
        end
      end
      if (a) begin
        if (oldkey == 0) mkey = (w && bus_sel == 1 && bus_wdata == 16'h0055) ? 1 : 0;
        else if (oldkey == 1) mkey = (w && bus_sel == 1 && bus_wdata == 16'h00AA) ? 2 : 0;
        else mkey = 0;
      end
      if (w) begin
        case (bus_sel)
          3'd0: begin
            if (bus_wdata[15]) begin
              int o;
              o = bus_wdata[1:0];
              ok = (oldkey == 2) && ((o == 1) || (o == 2 && maddr % 64 == 0) || (o == 3 && maddr % 512 == 0));
              merr = !ok;
              if (ok) mcnt = (o == 1) ? WDC : (o == 2) ? ROWC : ERC;
            end else merr = merr && bus_wdata[13];
            mop = bus_wdata[1:0];
          end
          3'd2: begin maddr = bus_wdata % NW; mptr = bus_wdata % 64; end
          3'd3: mlo = bus_wdata;
          3'd4: begin mbuf[mptr] = {bus_wdata[7:0], mlo}; mptr = (mptr + 1) % 64; mbw = 1; end
          default: ;
        endcase
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic es;
      es = (mcnt > 0) || mbw;
      checks++;
      if (stall !== es) begin
        fails++;
        $display("FAIL %s stall: actual %0b expected %0b", cur_req, stall, es);
      end
      if (bus_rd && !es) begin
        logic [15:0] ex;
        ex = exp_rdata(bus_sel);
        checks++;
        if (bus_rdata !== ex) begin
          fails++;
          $display("FAIL %s read sel %0d: actual %h expected %h", cur_req, bus_sel, bus_rdata, ex);
        end
      end
    end
  end

  task automatic xfer(input logic [2:0] s, input bit w, input bit r, input logic [15:0] d);
    @(negedge clk); #1;
    bus_sel = s; bus_wr = w; bus_rd = r; bus_wdata = d;
    @(negedge clk); #1;
    bus_wr = 0; bus_rd = 0;
    while (stall) begin @(negedge clk); #1; end
  endtask

  task automatic wr(input logic [2:0] s, input logic [15:0] d); xfer(s, 1, 0, d); endtask
  task automatic rd(input logic [2:0] s); xfer(s, 0, 1, 16'h0); endtask
  task automatic peek(input int a); wr(3'd2, 16'(a)); rd(3'd5); rd(3'd6); endtask
  task automatic unlock(); wr(3'd1, 16'h0055); wr(3'd1, 16'h00AA); endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1 rst_n = 1;
    cur_req = "R1"; rd(3'd0); peek(0); peek(700);
    cur_req = "R2"; rd(3'd1); wr(3'd1, 16'h0055); rd(3'd1);

    cur_req = "R8"; wr(3'd2, 16'd64);
    for (int i = 0; i < 64; i++) begin
      wr(3'd3, 16'(16'h1000 + i * 7));
      wr(3'd4, 16'(8'h30 + i));
    end
    cur_req = "R3"; unlock(); wr(3'd0, 16'h8002);
    cur_req = "R9"; rd(3'd0); peek(64); peek(100); peek(127); peek(63); peek(128);

    cur_req = "R6"; wr(3'd2, 16'd65); unlock(); wr(3'd0, 16'h8002); rd(3'd0); peek(65);
    cur_req = "R5"; wr(3'd2, 16'd128); wr(3'd0, 16'h8002); rd(3'd0); peek(128);
    cur_req = "R12"; wr(3'd0, 16'h0000); rd(3'd0);

    cur_req = "R4"; wr(3'd2, 16'd192);
    wr(3'd1, 16'h0055); rd(3'd0); wr(3'd1, 16'h00AA); wr(3'd0, 16'h8002); rd(3'd0); peek(192);
    wr(3'd1, 16'h0055); wr(3'd1, 16'h00AB); wr(3'd0, 16'h8002); rd(3'd0);
    unlock(); rd(3'd2); wr(3'd0, 16'h8002); rd(3'd0); peek(192);
    cur_req = "R6"; unlock(); wr(3'd0, 16'h8000); rd(3'd0);

    cur_req = "R11"; wr(3'd2, 16'd130); wr(3'd3, 16'hBEEF); wr(3'd4, 16'h005A);
    wr(3'd2, 16'd130); unlock(); wr(3'd0, 16'h8001); rd(3'd0);
    peek(130); peek(129); peek(131);
    wr(3'd2, 16'd600); wr(3'd3, 16'h1234); wr(3'd4, 16'h0077);
    wr(3'd2, 16'd600); unlock(); wr(3'd0, 16'h8001); peek(600);

    cur_req = "R6"; wr(3'd2, 16'd64); unlock(); wr(3'd0, 16'h8003); rd(3'd0); peek(64);
    cur_req = "R10"; wr(3'd2, 16'd0); unlock(); wr(3'd0, 16'h8003); rd(3'd0);
    peek(64); peek(127); peek(130); peek(511); peek(600);
    cur_req = "R7"; wr(3'd2, 16'd512); unlock(); wr(3'd0, 16'h8003); peek(600); peek(513);

    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule